// File: doc/BRIEF.md
# Serial Channel Register Core

This block is the register-facing core of one channel of an asynchronous serial port. A host reaches it through a small 8-bit register bus with a two-bit select. Through that bus the host issues commands, reads channel status, programs a pair of mode registers that share one select code, writes bytes to transmit and reads bytes that were received. Bit timing, baud generation and line handling sit outside this block.

Received characters arrive on a byte stream with valid/ready. A stream item can also be flagged as a line break. A break becomes a zero byte in the receive queue and raises the break status bit. Accepted transmit bytes leave as a single-cycle strobe with data. Three level flags (transmit ready, receive ready, break) go to an external interrupt aggregator.

Register reads are combinational. `reg_rdata_o` is valid in the same cycle as `reg_rd_i`, and the side effects of the read (queue pop, pointer advance) take effect at the clock edge that ends that cycle. Select codes: 0 is the mode pair, 1 is command (write) and status (read), 2 is the holding register (receive on read, transmit on write), and 3 is spare (reads zero, writes ignored).

Top module: `serchan_core`

## Requirements
- R1: A write to select 1 is a command. In the low nibble, bit 0 enables the receiver, bit 1 disables it, bit 2 enables the transmitter and bit 3 disables it. Enabling the transmitter sets status bits 2 and 3 and `txrdy_evt_o`. Disabling it clears all three. When the enable and disable bits of one direction are both set, the direction ends disabled.
- R2: Command bits 7:4 are an opcode. Opcode 0 does nothing. Opcode 2 disables the receiver, discards every queued byte and clears receive-ready (status bit 0 and `rxrdy_evt_o`); a byte offered in the same cycle is dropped. Opcode 3 clears status bits 2 and 3 and `txrdy_evt_o`.
- R3: Two mode registers share select 0. The first read or write after reset or after opcode 1 reaches mode register 1. Every later access reaches mode register 2 until opcode 1 is issued again.
- R4: Status bit order, bit 0 to bit 7: receive-ready, queue-full, transmit-ready, transmitter-empty, overrun, parity error, framing error, received break. Bits 4 to 6 read zero. Opcode 4 clears bits 4 to 7. Select 3 reads zero.
- R5: The receive queue is three entries deep and first-in first-out. A read of select 2 returns the oldest byte and removes it. Removing the last byte clears status bit 0 and `rxrdy_evt_o`.
- R6: A byte accepted into an empty queue sets status bit 0 and `rxrdy_evt_o`. A push and a holding read in the same cycle return the old head and keep the new byte in order.
- R7: A break item (`rx_break_i` with valid) is accepted like a byte and queues 0x00. If status bit 7 was clear, it sets bit 7 and `brk_evt_o`; otherwise it leaves both unchanged.
- R8: A holding read that removes a byte while status bit 7 is set clears bit 7 and sets `brk_evt_o`. Opcode 5 clears `brk_evt_o`.
- R9: A write to select 2 while transmit-ready is set produces `tx_valid_o` for exactly one cycle, on the cycle after the write, carrying the written byte. A write made while transmit-ready is clear produces no strobe.
- R10: `rx_ready_o` is high only when the receiver is enabled and fewer than three bytes are queued. Status bit 1 is set when three bytes are queued.
- R11: A holding read with an empty queue returns the byte removed last (0x00 if none since reset) and changes no state.
- R12: After reset, the receiver and transmitter are disabled, the mode pointer selects register 1, all status bits and flags are zero, the queue is empty and `tx_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register select: 0 mode, 1 command/status, 2 holding, 3 spare |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the current select |
| rx_valid_i | input | 1 | Receive stream item valid |
| rx_data_i | input | 8 | Received byte |
| rx_break_i | input | 1 | Item is a break; data is ignored and 0x00 is queued |
| rx_ready_o | output | 1 | Receive stream ready |
| tx_valid_o | output | 1 | One-cycle transmit strobe |
| tx_data_o | output | 8 | Transmit byte |
| txrdy_evt_o | output | 1 | Transmit-ready event flag |
| rxrdy_evt_o | output | 1 | Receive-ready event flag |
| brk_evt_o | output | 1 | Break event flag |

## Verification
Two functions can fall in the same cycle: a byte arriving on the receive stream and a host read of the holding register. The bench provokes this by holding `rx_valid_i` and a holding read in one clock cycle while exactly one byte is queued. The read must return the older byte, receive-ready must stay set, and the next read must return the new byte. A second overlap is also driven: a break arrives while the break bit is still set and a clear command is pending. The bench then checks that the break flag is not raised a second time.

// File: rtl/serchan_pkg.sv
package serchan_pkg;
  typedef enum logic [1:0] {
    SEL_MODE  = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_HOLD  = 2'd2,
    SEL_SPARE = 2'd3
  } reg_sel_e;

  localparam logic [3:0] OP_NOP     = 4'd0;
  localparam logic [3:0] OP_PTR_RST = 4'd1;
  localparam logic [3:0] OP_RX_RST  = 4'd2;
  localparam logic [3:0] OP_TX_RST  = 4'd3;
  localparam logic [3:0] OP_ERR_CLR = 4'd4;
  localparam logic [3:0] OP_BRK_CLR = 4'd5;

  localparam int CMD_RX_ON  = 0;
  localparam int CMD_RX_OFF = 1;
  localparam int CMD_TX_ON  = 2;
  localparam int CMD_TX_OFF = 3;

  localparam int ST_RXRDY = 0;
  localparam int ST_FULL  = 1;
  localparam int ST_TXRDY = 2;
  localparam int ST_TXEMT = 3;
  localparam int ST_BRK   = 7;
endpackage

// File: rtl/serchan_rxq.sv
module serchan_rxq #(
  parameter int DW = 8,
  parameter int DEPTH = 3,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [DW-1:0]    push_data_i,
  input  logic             pop_i,
  output logic [DW-1:0]    head_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SUM_W = CNT_W + 1;

  logic [DW-1:0]    mem_q [DEPTH];
  logic [IDX_W-1:0] rd_idx_q, wr_idx;
  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] sum;
  logic             advance;

  assign sum     = SUM_W'(rd_idx_q) + SUM_W'(cnt_q);
  assign wr_idx  = (sum >= SUM_W'(DEPTH)) ? IDX_W'(sum - SUM_W'(DEPTH)) : IDX_W'(sum);
  // keep head on the last read byte unless a newer one exists
  assign advance = pop_i && ((cnt_q > CNT_W'(1)) || push_i);
  assign head_o  = mem_q[rd_idx_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_idx_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      cnt_q <= '0;
    end else begin
      if (advance)
        rd_idx_q <= (rd_idx_q == IDX_W'(DEPTH - 1)) ? '0 : rd_idx_q + 1'b1;
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (!push_i && pop_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                           mem_q[g] <= '0;
      else if (push_i && !flush_i && wr_idx == IDX_W'(g))    mem_q[g] <= push_data_i;
    end
  end
endmodule

// File: rtl/serchan_mode.sv
module serchan_mode #(
  parameter int DW = 8,
  parameter int NREG = 2,
  localparam int PTR_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ptr_rst_i,
  input  logic             acc_i,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [PTR_W-1:0] ptr_o
);
  logic [DW-1:0]    regs_q [NREG];
  logic [PTR_W-1:0] ptr_q;

  assign rdata_o = regs_q[ptr_q];
  assign ptr_o   = ptr_q;

  // pointer climbs to the last register and parks there
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                      ptr_q <= '0;
    else if (ptr_rst_i)                               ptr_q <= '0;
    else if (acc_i && ptr_q != PTR_W'(NREG - 1))      ptr_q <= ptr_q + 1'b1;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs_q[g] <= '0;
      else if (wr_i && ptr_q == PTR_W'(g))       regs_q[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/serchan_core.sv
module serchan_core #(
  parameter int DW = 8,
  parameter int RXQ_DEPTH = 3,
  parameter int MODE_REGS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    reg_addr_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_break_i,
  output logic          rx_ready_o,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  output logic          txrdy_evt_o,
  output logic          rxrdy_evt_o,
  output logic          brk_evt_o
);
  import serchan_pkg::*;

  localparam int CNT_W = $clog2(RXQ_DEPTH + 1);
  localparam int PTR_W = (MODE_REGS > 1) ? $clog2(MODE_REGS) : 1;

  logic             cmd_wr, hold_wr, hold_rd, mode_acc, mode_wr, ptr_rst, flush;
  logic             push, pop, fifo_full, rxrdy, brk_arrive, pop_brk, mode_ptr_nz;
  logic [3:0]       opcode;
  logic [CNT_W-1:0] q_cnt;
  logic [DW-1:0]    q_head, mode_rdata, push_data;
  logic [PTR_W-1:0] mode_ptr;
  logic [7:0]       status;
  logic             rx_en_q, rx_en_d, tx_on_q, tx_on_d;
  logic             brk_q, brk_d, brk_evt_q, brk_evt_d;
  logic             tx_valid_q;
  logic [DW-1:0]    tx_data_q;

  assign opcode   = reg_wdata_i[7:4];
  assign cmd_wr   = reg_wr_i && reg_addr_i == SEL_CTRL;
  assign hold_wr  = reg_wr_i && reg_addr_i == SEL_HOLD;
  assign hold_rd  = reg_rd_i && reg_addr_i == SEL_HOLD;
  assign mode_wr  = reg_wr_i && reg_addr_i == SEL_MODE;
  assign mode_acc = (reg_wr_i || reg_rd_i) && reg_addr_i == SEL_MODE;
  assign ptr_rst  = cmd_wr && opcode == OP_PTR_RST;
  assign flush    = cmd_wr && opcode == OP_RX_RST;

  assign fifo_full  = q_cnt == CNT_W'(RXQ_DEPTH);
  assign rxrdy      = q_cnt != '0;
  assign rx_ready_o = rx_en_q && !fifo_full;
  assign push       = rx_valid_i && rx_ready_o && !flush;
  assign push_data  = rx_break_i ? '0 : rx_data_i;
  assign pop        = hold_rd && rxrdy;
  assign brk_arrive = push && rx_break_i && !brk_q;
  assign pop_brk    = pop && brk_q;
  assign mode_ptr_nz = |mode_ptr;

  serchan_rxq #(.DW(DW), .DEPTH(RXQ_DEPTH)) u_rxq (
    .clk_i, .rst_ni,
    .flush_i(flush), .push_i(push), .push_data_i(push_data),
    .pop_i(pop), .head_o(q_head), .count_o(q_cnt)
  );

  serchan_mode #(.DW(DW), .NREG(MODE_REGS)) u_mode (
    .clk_i, .rst_ni,
    .ptr_rst_i(ptr_rst), .acc_i(mode_acc), .wr_i(mode_wr),
    .wdata_i(reg_wdata_i), .rdata_o(mode_rdata), .ptr_o(mode_ptr)
  );

  always_comb begin
    rx_en_d = rx_en_q;
    tx_on_d = tx_on_q;
    if (cmd_wr) begin
      if (reg_wdata_i[CMD_RX_ON])  rx_en_d = 1'b1;
      if (reg_wdata_i[CMD_RX_OFF]) rx_en_d = 1'b0;
      if (reg_wdata_i[CMD_TX_ON])  tx_on_d = 1'b1;
      if (reg_wdata_i[CMD_TX_OFF]) tx_on_d = 1'b0;
      if (opcode == OP_RX_RST)     rx_en_d = 1'b0;
      if (opcode == OP_TX_RST)     tx_on_d = 1'b0;
    end
    // a fresh break wins over a same-cycle clear
    brk_d = brk_q;
    if (brk_arrive)                             brk_d = 1'b1;
    else if (pop_brk)                           brk_d = 1'b0;
    else if (cmd_wr && opcode == OP_ERR_CLR)    brk_d = 1'b0;
    brk_evt_d = brk_evt_q;
    if (brk_arrive || pop_brk)                  brk_evt_d = 1'b1;
    else if (cmd_wr && opcode == OP_BRK_CLR)    brk_evt_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_q    <= 1'b0;
      tx_on_q    <= 1'b0;
      brk_q      <= 1'b0;
      brk_evt_q  <= 1'b0;
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      rx_en_q    <= rx_en_d;
      tx_on_q    <= tx_on_d;
      brk_q      <= brk_d;
      brk_evt_q  <= brk_evt_d;
      tx_valid_q <= hold_wr && tx_on_q;
      if (hold_wr && tx_on_q) tx_data_q <= reg_wdata_i;
    end
  end

  always_comb begin
    status           = '0;
    status[ST_RXRDY] = rxrdy;
    status[ST_FULL]  = fifo_full;
    status[ST_TXRDY] = tx_on_q;
    status[ST_TXEMT] = tx_on_q;
    status[ST_BRK]   = brk_q;
    unique case (reg_addr_i)
      SEL_MODE: reg_rdata_o = mode_rdata;
      SEL_CTRL: reg_rdata_o = DW'(status);
      SEL_HOLD: reg_rdata_o = q_head;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign tx_valid_o  = tx_valid_q;
  assign tx_data_o   = tx_data_q;
  assign txrdy_evt_o = tx_on_q;
  assign rxrdy_evt_o = rxrdy;
  assign brk_evt_o   = brk_evt_q;
endmodule

// File: rtl/serchan_core_chk.sv
module serchan_core_chk #(
  parameter int DW = 8,
  parameter int CNT_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_ready_o,
  input logic             tx_valid_o,
  input logic             txrdy_evt_o,
  input logic             rxrdy_evt_o,
  input logic             brk_evt_o,
  input logic             fifo_full,
  input logic             cmd_wr,
  input logic [DW-1:0]    reg_wdata_i,
  input logic             mode_acc,
  input logic             ptr_rst,
  input logic             mode_ptr_nz,
  input logic             push,
  input logic             pop,
  input logic [CNT_W-1:0] q_cnt,
  input logic             brk_arrive
);
  // R1
  tx_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && reg_wdata_i[2] && !reg_wdata_i[3] && reg_wdata_i[7:4] != 4'd3) |=> txrdy_evt_o);
  // R2
  rx_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && reg_wdata_i[7:4] == 4'd2) |=> (!rx_ready_o && !rxrdy_evt_o));
  // R3
  ptr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_acc && !ptr_rst) |=> mode_ptr_nz);
  // R5
  last_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && !push && q_cnt == CNT_W'(1)) |=> !rxrdy_evt_o);
  // R6
  first_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && q_cnt == '0) |=> rxrdy_evt_o);
  // R7
  brk_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_arrive |=> brk_evt_o);
  // R9
  tx_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(txrdy_evt_o));
  // R10
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |-> !fifo_full);
endmodule

bind serchan_core serchan_core_chk #(.DW(DW), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/serchan_core_test.sv
`timescale 1ns/1ps
module serchan_core_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic       reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       rx_valid_i = 1'b0, rx_break_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       rx_ready_o, tx_valid_o, txrdy_evt_o, rxrdy_evt_o, brk_evt_o;
  logic [7:0] tx_data_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serchan_core uut (
    .clk_i(clk), .rst_ni, .reg_addr_i, .reg_wr_i, .reg_rd_i, .reg_wdata_i,
    .reg_rdata_o, .rx_valid_i, .rx_data_i, .rx_break_i, .rx_ready_o,
    .tx_valid_o, .tx_data_o, .txrdy_evt_o, .rxrdy_evt_o, .brk_evt_o
  );

  localparam logic [1:0] MODE = 2'd0, CTRL = 2'd1, HOLD = 2'd2, SPARE = 2'd3;
  localparam logic [1:0] OW = 2'd0, ORD = 2'd1, OPU = 2'd2, OBK = 2'd3;
  // {op, select, requirement, data-or-expected}
  localparam int NV = 26;
  localparam logic [15:0] VEC [NV] = '{
    {OW,  CTRL, 4'd3,  8'h10}, {OW,  MODE, 4'd3,  8'hA5}, {OW,  MODE, 4'd3,  8'h5A},
    {ORD, MODE, 4'd3,  8'h5A}, {OW,  CTRL, 4'd3,  8'h10}, {ORD, MODE, 4'd3,  8'hA5},
    {ORD, MODE, 4'd3,  8'h5A}, {OW,  CTRL, 4'd1,  8'h05}, {ORD, CTRL, 4'd1,  8'h0C},
    {OPU, HOLD, 4'd5,  8'h11}, {OPU, HOLD, 4'd5,  8'h22}, {OPU, HOLD, 4'd5,  8'h33},
    {ORD, CTRL, 4'd10, 8'h0F}, {ORD, HOLD, 4'd5,  8'h11}, {ORD, HOLD, 4'd5,  8'h22},
    {ORD, CTRL, 4'd5,  8'h0D}, {ORD, HOLD, 4'd5,  8'h33}, {ORD, CTRL, 4'd5,  8'h0C},
    {ORD, HOLD, 4'd11, 8'h33}, {ORD, CTRL, 4'd11, 8'h0C}, {OBK, HOLD, 4'd7,  8'h00},
    {ORD, CTRL, 4'd7,  8'h8D}, {ORD, HOLD, 4'd7,  8'h00}, {ORD, CTRL, 4'd8,  8'h0C},
    {OW,  CTRL, 4'd1,  8'h0A}, {ORD, CTRL, 4'd1,  8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(posedge clk); #2;
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_addr_i = a; reg_rd_i = 1'b1;
    #1 chk(tag, reg_rdata_o, exp);
    @(posedge clk); #2;
    reg_rd_i = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input logic brk);
    @(negedge clk);
    rx_valid_i = 1'b1; rx_data_i = d; rx_break_i = brk;
    @(posedge clk); #2;
    rx_valid_i = 1'b0; rx_break_i = 1'b0;
  endtask

  task automatic push_and_read(input logic [7:0] d, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rx_valid_i = 1'b1; rx_data_i = d; reg_addr_i = HOLD; reg_rd_i = 1'b1;
    #1 chk(tag, reg_rdata_o, exp);
    @(posedge clk); #2;
    rx_valid_i = 1'b0; reg_rd_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #3;
    chk("R12 rx_ready", {7'd0, rx_ready_o}, 8'h00);
    chk("R12 flags", {5'd0, txrdy_evt_o, rxrdy_evt_o, brk_evt_o}, 8'h00);
    chk("R12 tx_valid", {7'd0, tx_valid_o}, 8'h00);
    rd(CTRL, 8'h00, "R12 status");
    rd(HOLD, 8'h00, "R12 empty holding");

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op, a;
      logic [3:0] rq;
      logic [7:0] d;
      {op, a, rq, d} = VEC[i];
      case (op)
        OW:  wr(a, d);
        ORD: rd(a, d, $sformatf("R%0d vec%0d", rq, i));
        OPU: push(d, 1'b0);
        default: push(8'h00, 1'b1);
      endcase
    end

    // R8 opcode 5 clears the break flag
    chk("R8 flag before clear", {7'd0, brk_evt_o}, 8'h01);
    wr(CTRL, 8'h50); #3;
    chk("R8 opcode 5", {7'd0, brk_evt_o}, 8'h00);

    // R9 transmit gating and strobe width
    wr(HOLD, 8'h77); #3;
    chk("R9 discard when off", {7'd0, tx_valid_o}, 8'h00);
    wr(CTRL, 8'h04);
    wr(HOLD, 8'hC3); #3;
    chk("R9 strobe", {7'd0, tx_valid_o}, 8'h01);
    chk("R9 data", tx_data_o, 8'hC3);
    @(posedge clk); #3;
    chk("R9 one cycle", {7'd0, tx_valid_o}, 8'h00);
    wr(CTRL, 8'h30); #3;
    chk("R2 tx reset flag", {7'd0, txrdy_evt_o}, 8'h00);
    rd(CTRL, 8'h00, "R2 tx reset status");

    // R1 enable plus disable in one command
    wr(CTRL, 8'h03); #3;
    chk("R1 rx both bits", {7'd0, rx_ready_o}, 8'h00);
    wr(CTRL, 8'h01); #3;
    chk("R10 ready when enabled", {7'd0, rx_ready_o}, 8'h01);
    wr(CTRL, 8'h0C); #3;
    chk("R1 tx both bits", {7'd0, txrdy_evt_o}, 8'h00);

    // R6 push and read in the same cycle
    push(8'h44, 1'b0); #3;
    chk("R6 rxrdy flag", {7'd0, rxrdy_evt_o}, 8'h01);
    push_and_read(8'h55, 8'h44, "R6 overlap head");
    rd(CTRL, 8'h01, "R6 overlap status");
    rd(HOLD, 8'h55, "R6 overlap order");
    rd(CTRL, 8'h00, "R5 drained");
    #3 chk("R5 rxrdy flag clear", {7'd0, rxrdy_evt_o}, 8'h00);

    // R10 full queue
    push(8'hA1, 1'b0); push(8'hA2, 1'b0); push(8'hA3, 1'b0); #3;
    chk("R10 not ready when full", {7'd0, rx_ready_o}, 8'h00);
    rd(CTRL, 8'h03, "R10 full bit");

    // R2 receiver reset discards queue
    wr(CTRL, 8'h20); #3;
    chk("R2 ready low", {7'd0, rx_ready_o}, 8'h00);
    chk("R2 rxrdy flag", {7'd0, rxrdy_evt_o}, 8'h00);
    rd(CTRL, 8'h00, "R2 status");
    wr(CTRL, 8'h01);
    push(8'h66, 1'b0);
    rd(HOLD, 8'h66, "R2 old bytes gone");

    // R7 second break while bit set; R4 error clear
    push(8'hFF, 1'b1); #3;
    chk("R7 flag set", {7'd0, brk_evt_o}, 8'h01);
    wr(CTRL, 8'h50);
    push(8'hFF, 1'b1); #3;
    chk("R7 no re-raise", {7'd0, brk_evt_o}, 8'h00);
    rd(CTRL, 8'h81, "R7 status");
    wr(CTRL, 8'h40);
    rd(CTRL, 8'h01, "R4 opcode 4");
    rd(HOLD, 8'h00, "R7 zero byte");
    #3 chk("R8 no flag without bit", {7'd0, brk_evt_o}, 8'h00);
    rd(HOLD, 8'h00, "R7 zero byte 2");

    // R11 empty reads change nothing
    rd(HOLD, 8'h00, "R11 empty read");
    rd(HOLD, 8'h00, "R11 empty read again");
    rd(CTRL, 8'h00, "R11 status");
    rd(SPARE, 8'h00, "R4 spare select");

    // R3 pointer reset
    wr(CTRL, 8'h10);
    rd(MODE, 8'hA5, "R3 pointer reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule